// File: doc/BRIEF.md
# Edge-Triggered Set/Clear Flip-Flop

This block stores one bit that is set by a rising edge on one input and cleared by a rising edge on another, rather than by the levels of those inputs. Both inputs may arrive from outside the clock domain. Each one passes through a multi-stage synchronizer and then an edge detector running on the system clock, so the whole block is ordinary synthesizable logic.

The stored bit is not held in one register. It is the exclusive-OR of two toggle registers. A set edge flips the first register, but only while the output is low. A clear edge flips the second register, but only while the output is high. An edge that would not change the output therefore changes nothing. When both edges are detected in the same clock cycle, only the one that changes the output takes effect, so the output toggles exactly once. A one-cycle pulse marks each cycle in which the output has just changed.

Top module: `edsr_flop`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, q_o is 0 and q_changed_o is 0.
- R2: The two internal toggle registers never both change in the same clock cycle, so each update moves q_o by at most one step.
- R3: A rising edge on set_i while q_o is 0 drives q_o to 1.
- R4: A rising edge on clr_i while q_o is 1 drives q_o to 0.
- R5: A rising edge on set_i while q_o is 1, a rising edge on clr_i while q_o is 0, and any falling edge on either input leave q_o unchanged.
- R6: When rising edges on set_i and clr_i are detected in the same cycle, q_o toggles exactly once. It goes to 1 if it was 0 and to 0 if it was 1.
- R7: An input held high causes no further action. Only a fresh 0-to-1 transition is acted on, and the internal edge flag never stays high for two cycles in a row.
- R8: Suppose an input rises between two clock edges. With SYNC_STAGES=2, q_o shows the new value after the third rising clock edge following that change, and not before.
- R9: q_changed_o is 1 for exactly the cycle in which q_o has just taken a new value, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| set_i | input | 1 | Asynchronous set request, acted on at its rising edge |
| clr_i | input | 1 | Asynchronous clear request, acted on at its rising edge |
| q_o | output | 1 | Stored bit |
| q_changed_o | output | 1 | One-cycle pulse after each change of q_o |

## Verification
The bench applies every sequence of four actions drawn from none, set, clear and both. This reaches redundant edges and coincident edges from both output states. A design that let a redundant edge flip its register would invert q_o. One that applied both coincident edges would leave q_o unchanged. One that gave either input fixed priority would fail half of the coincident cases. The bench also checks that q_o stays put for the two cycles before the expected edge and that falling inputs do nothing. This catches a synchronizer with a missing or extra stage and a detector that fires on the wrong polarity. A long held-high level after an opposing edge exposes a detector that acts on levels instead of transitions.

// File: rtl/edsr_pkg.sv
package edsr_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_SET = 0;
  localparam int unsigned CH_CLR = 1;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'b00,
    ACT_SET   = 2'b01,
    ACT_CLEAR = 2'b10
  } act_e;
endpackage

// File: rtl/edsr_sync.sv
module edsr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[N-2:0], d_i};
  end

  assign q_o = chain_q[N-1];
endmodule

// File: rtl/edsr_edge_detect.sv
module edsr_edge_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/edsr_toggle_core.sv
module edsr_toggle_core
  import edsr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_rise_i,
  input  logic clr_rise_i,
  output logic tog_a_o,
  output logic tog_b_o,
  output logic q_o,
  output logic changed_o
);
  act_e act;
  logic tog_a_q, tog_b_q, changed_q;
  logic q_now;

  assign q_now = tog_a_q ^ tog_b_q;

  // only the edge that moves q is applied; covers coincident edges too
  always_comb begin
    act = ACT_NONE;
    if (set_rise_i && !q_now)     act = ACT_SET;
    else if (clr_rise_i && q_now) act = ACT_CLEAR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_a_q   <= 1'b0;
      tog_b_q   <= 1'b0;
      changed_q <= 1'b0;
    end else begin
      if (act == ACT_SET)   tog_a_q <= ~tog_a_q;
      if (act == ACT_CLEAR) tog_b_q <= ~tog_b_q;
      changed_q <= (act != ACT_NONE);
    end
  end

  assign tog_a_o   = tog_a_q;
  assign tog_b_o   = tog_b_q;
  assign q_o       = q_now;
  assign changed_o = changed_q;
endmodule

// File: rtl/edsr_flop.sv
module edsr_flop
  import edsr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic q_changed_o
);
  logic [NUM_CH-1:0] raw_in;
  logic [NUM_CH-1:0] sync_lvl;
  logic [NUM_CH-1:0] rise;
  logic tog_a, tog_b;

  assign raw_in[CH_SET] = set_i;
  assign raw_in[CH_CLR] = clr_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    edsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_in[g]),
      .q_o    (sync_lvl[g])
    );
    edsr_edge_detect u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (sync_lvl[g]),
      .rise_o (rise[g])
    );
  end

  edsr_toggle_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_rise_i (rise[CH_SET]),
    .clr_rise_i (rise[CH_CLR]),
    .tog_a_o    (tog_a),
    .tog_b_o    (tog_b),
    .q_o        (q_o),
    .changed_o  (q_changed_o)
  );
endmodule

// File: rtl/edsr_flop_checker.sv
module edsr_flop_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       q_o,
  input logic       q_changed_o,
  input logic [1:0] rise,
  input logic       tog_a,
  input logic       tog_b
);
  assert_single_mover_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> !((tog_a != $past(tog_a)) && (tog_b != $past(tog_b))));

  assert_set_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise[0] && !q_o) |=> q_o);

  assert_clear_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise[1] && q_o) |=> !q_o);

  assert_hold_otherwise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(rise[0] && !q_o) && !(rise[1] && q_o)) |=> $stable(q_o));

  assert_coincident_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise[0] && rise[1]) |=> (q_o != $past(q_o)));

  assert_edge_not_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise[0] |=> !rise[0]);

  assert_edge_not_level_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise[1] |=> !rise[1]);

  assert_pulse_matches_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (q_changed_o == (q_o != $past(q_o))));
endmodule

bind edsr_flop edsr_flop_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .q_o         (q_o),
  .q_changed_o (q_changed_o),
  .rise        (rise),
  .tog_a       (tog_a),
  .tog_b       (tog_b)
);

// File: tb/edsr_flop_tb.sv
module edsr_flop_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic set_i = 1'b0;
  logic clr_i = 1'b0;
  logic q_o, q_changed_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic q_exp = 1'b0;

  always #2 clk_i = ~clk_i;

  edsr_flop #(.SYNC_STAGES(2)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (set_i),
    .clr_i       (clr_i),
    .q_o         (q_o),
    .q_changed_o (q_changed_o)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; set_i = 1'b0; clr_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(q_o, 1'b0, "R1 q in reset");
    chk(q_changed_o, 1'b0, "R1 pulse in reset");
    rst_ni = 1'b1;
    q_exp = 1'b0;
  endtask

  // drives at a negedge; q must move after the third posedge
  task automatic apply(input logic s, input logic r);
    logic old_q, nxt;
    old_q = q_exp;
    nxt = q_exp;
    if (s && !q_exp)     nxt = 1'b1;
    else if (r && q_exp) nxt = 1'b0;
    set_i = s; clr_i = r;
    repeat (2) begin
      @(negedge clk_i);
      chk(q_o, old_q, "R8 early");
      chk(q_changed_o, 1'b0, "R9 early pulse");
    end
    @(negedge clk_i);
    if (s && r)                 chk(q_o, nxt, "R6 coincident");
    else if (s && !old_q)       chk(q_o, nxt, "R3 set");
    else if (r && old_q)        chk(q_o, nxt, "R4 clear");
    else                        chk(q_o, nxt, "R5 no effect");
    chk(q_changed_o, nxt != old_q, "R9 pulse");
    q_exp = nxt;
    @(negedge clk_i);
    chk(q_changed_o, 1'b0, "R9 pulse width");
    set_i = 1'b0; clr_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(q_o, q_exp, "R5 falling edge");
    chk(q_changed_o, 1'b0, "R9 no pulse on fall");
  endtask

  initial begin
    do_reset();
    @(negedge clk_i);
    chk(q_o, 1'b0, "R1 after release");
    chk(q_changed_o, 1'b0, "R1 pulse after release");

    // exhaustive: 4 actions x 4 steps
    for (int seq = 0; seq < 256; seq++) begin
      do_reset();
      @(negedge clk_i);
      for (int k = 0; k < 4; k++) begin
        int a;
        a = (seq >> (2 * k)) & 3;
        if (a == 0) begin
          repeat (3) @(negedge clk_i);
          chk(q_o, q_exp, "R5 idle");
        end else begin
          apply(a[0], a[1]);
        end
      end
    end

    // held level: set stays high across a clear edge
    do_reset();
    @(negedge clk_i);
    set_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(q_o, 1'b1, "R3 held set");
    clr_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(q_o, 1'b0, "R4 clear while set held");
    clr_i = 1'b0;
    repeat (12) @(negedge clk_i);
    chk(q_o, 1'b0, "R7 held set no retrigger");
    chk(q_changed_o, 1'b0, "R7 no pulse");
    set_i = 1'b0;
    repeat (4) @(negedge clk_i);
    set_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(q_o, 1'b1, "R7 fresh edge acts");
    set_i = 1'b0;
    repeat (4) @(negedge clk_i);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule